// File: doc/BRIEF.md
# Sign-Magnitude Double-Minus-One Chain

This block takes a small signed number in sign-magnitude form and returns y = 2x - 1, also in sign-magnitude form. It is purely combinational and is built as four stages in a row.

The first stage turns the sign-magnitude input into two's complement. The second stage doubles that value and subtracts one, giving a result one bit wider. The third stage negates that result by inverting it and adding one through a chain of half adders. The fourth stage uses the negated value and a 2:1 multiplexer to recover the magnitude and sign.

The output of every stage is brought out on a port so that each step can be checked on its own. The input code for negative zero is treated as zero, so it produces y = -1.

Top module: `sm_affine_top`

## Requirements
- R1: Input `x_sm` bit 2 is the sign (0 positive, 1 negative) and bits 1..0 are the magnitude. For a positive code, `a_tc` equals {0, magnitude}: 000→000, 001→001, 010→010, 011→011.
- R2: For a negative code with nonzero magnitude, `a_tc` is the 3-bit two's complement of minus the magnitude: 101→111, 110→110, 111→101.
- R3: The negative-zero code 100 gives `a_tc` = 000, and the rest of the chain treats it exactly like input 000.
- R4: `b_tc` equals 2·a − 1 as a 4-bit two's complement value, for example a=0→1111, a=3→0101, a=−3→1001.
- R5: `neg_tc` is the 4-bit two's complement negation of `b_tc`, so that `b_tc` + `neg_tc` ≡ 0 mod 16.
- R6: `y_sign` is 1 exactly when the result is negative, that is, when bit 3 of `b_tc` is 1.
- R7: `y_mag` is the absolute value of the result in 3 bits. It is always odd and never exceeds 7.
- R8: For every one of the eight input codes, {`y_sign`, `y_mag`} encodes 2x − 1, where input 100 counts as x = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_sm | input | 3 | Sign-magnitude operand: sign in bit 2, magnitude in bits 1..0 |
| a_tc | output | 3 | Stage 1: operand in two's complement |
| b_tc | output | 4 | Stage 2: 2·a − 1 in two's complement |
| neg_tc | output | 4 | Stage 3: negation of b_tc |
| y_mag | output | 3 | Stage 4: magnitude of the result |
| y_sign | output | 1 | Stage 4: 1 when the result is negative |

## Verification
The bench targets three corner cases.

- Negative zero: a converter that simply inverted and incremented code 100 would produce `a_tc` = 100 instead of 000, and the result would come out as −9 folded into garbage instead of −1.
- The most negative result, −7 from input 111: a negator with a broken carry chain, or a multiplexer whose select is inverted, would return 1001 as the magnitude, or would report a positive value.
- The crossing from y = −1 to y = +1 (inputs 000 and 001): a wrong subtract-one or a wrong sign bit would show up here.

// File: rtl/sm_affine_pkg.sv
package sm_affine_pkg;

    localparam int MAG_W = 2;
    localparam int TC_W  = MAG_W + 1;
    localparam int RES_W = TC_W + 1;

    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;

    typedef struct packed {
        sign_e            sign;
        logic [MAG_W-1:0] mag;
    } sm_in_t;

    typedef struct packed {
        sign_e            sign;
        logic [TC_W-1:0]  mag;
    } sm_out_t;

    // Most negative two's complement code of the stage-1 width
    localparam logic [TC_W-1:0] TC_MIN = {1'b1, {MAG_W{1'b0}}};

    // Doubling then decrement; the unreachable minimum code maps to zero
    function automatic logic [RES_W-1:0] double_less_one(input logic [TC_W-1:0] a);
        if (a == TC_MIN)
            return '0;
        return {a, 1'b0} - RES_W'(1);
    endfunction

endpackage

// File: rtl/sm_to_tc_stage.sv
module sm_to_tc_stage
    import sm_affine_pkg::*;
(
    input  sm_in_t          x_in,
    output logic [TC_W-1:0] a_out
);

    logic [TC_W-1:0] mag_ext;

    always_comb begin
        mag_ext = {1'b0, x_in.mag};
        if (x_in.sign == SIGN_NEG)
            a_out = ~mag_ext + TC_W'(1);
        else
            a_out = mag_ext;
    end

    always_comb begin
        if (!$isunknown(x_in)) begin
            if (x_in.sign == SIGN_NEG && x_in.mag == '0)
                AST_NEG_ZERO_FOLD: assert (a_out == '0); // R3
            if (x_in.sign == SIGN_POS)
                AST_POS_PASS: assert (a_out[TC_W-1] == 1'b0 && a_out[MAG_W-1:0] == x_in.mag); // R1
            if (x_in.sign == SIGN_NEG && x_in.mag != '0)
                AST_NEG_MSB: assert (a_out[TC_W-1] == 1'b1); // R2
        end
    end

endmodule

// File: rtl/affine_stage.sv
module affine_stage
    import sm_affine_pkg::*;
(
    input  logic [TC_W-1:0]  a_in,
    output logic [RES_W-1:0] b_out
);

    always_comb begin
        b_out = double_less_one(a_in);
    end

    always_comb begin
        if (!$isunknown(a_in) && a_in != TC_MIN) begin
            AST_RESULT_ODD: assert (b_out[0] == 1'b1); // R4
            AST_RESULT_SIGN: assert (b_out[RES_W-1] == (a_in[TC_W-1] || a_in == '0)); // R4
        end
    end

endmodule

// File: rtl/tc_negator.sv
module tc_negator
    import sm_affine_pkg::*;
(
    input  logic [RES_W-1:0] v_in,
    output logic [RES_W-1:0] v_neg
);

    logic [RES_W-1:0] ones_c;
    logic [RES_W:0]   carry;

    assign ones_c   = ~v_in;
    assign carry[0] = 1'b1;

    // Increment as a ripple of half adders
    for (genvar i = 0; i < RES_W; i++) begin : g_half_add
        assign v_neg[i]   = ones_c[i] ^ carry[i];
        assign carry[i+1] = ones_c[i] & carry[i];
    end

    always_comb begin
        if (!$isunknown(v_in))
            AST_NEG_SUM_ZERO: assert (RES_W'(v_in + v_neg) == '0); // R5
    end

endmodule

// File: rtl/tc_to_sm_stage.sv
module tc_to_sm_stage
    import sm_affine_pkg::*;
(
    input  logic [RES_W-1:0] b_in,
    input  logic [RES_W-1:0] b_neg,
    output sm_out_t          y_out
);

    logic [RES_W-1:0] chosen;
    logic             sel;

    assign sel = b_in[RES_W-1];

    // Bitwise 2:1 selection between the value and its negation
    for (genvar i = 0; i < RES_W; i++) begin : g_mux
        assign chosen[i] = sel ? b_neg[i] : b_in[i];
    end

    assign y_out.sign = sign_e'(sel);
    assign y_out.mag  = chosen[TC_W-1:0];

    always_comb begin
        if (!$isunknown(b_in) && b_in != {1'b1, {(RES_W-1){1'b0}}}) begin
            AST_MAG_FITS: assert (chosen[RES_W-1] == 1'b0); // R7
            if (b_in[0])
                AST_MAG_ODD: assert (y_out.mag[0] == 1'b1); // R7
        end
    end

endmodule

// File: rtl/sm_affine_top.sv
module sm_affine_top
    import sm_affine_pkg::*;
(
    input  logic [2:0] x_sm,
    output logic [2:0] a_tc,
    output logic [3:0] b_tc,
    output logic [3:0] neg_tc,
    output logic [2:0] y_mag,
    output logic       y_sign
);

    sm_in_t           x_s;
    logic [TC_W-1:0]  a_w;
    logic [RES_W-1:0] b_w;
    logic [RES_W-1:0] n_w;
    sm_out_t          y_w;

    assign x_s = sm_in_t'(x_sm);

    sm_to_tc_stage u_s1 (.x_in(x_s), .a_out(a_w));
    affine_stage   u_s2 (.a_in(a_w), .b_out(b_w));
    tc_negator     u_s3 (.v_in(b_w), .v_neg(n_w));
    tc_to_sm_stage u_s4 (.b_in(b_w), .b_neg(n_w), .y_out(y_w));

    assign a_tc   = a_w;
    assign b_tc   = b_w;
    assign neg_tc = n_w;
    assign y_mag  = y_w.mag;
    assign y_sign = y_w.sign;

    always_comb begin
        if (!$isunknown(x_sm))
            AST_SIGN_MATCH: assert (y_sign == b_tc[3]); // R6
    end

endmodule

// File: tb/sim_sm_affine_top.sv
module sim_sm_affine_top;

    logic       clk = 1'b0;
    logic [2:0] x_sm = 3'b000;
    logic [2:0] a_tc;
    logic [3:0] b_tc;
    logic [3:0] neg_tc;
    logic [2:0] y_mag;
    logic       y_sign;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sm_affine_top u0 (
        .x_sm(x_sm), .a_tc(a_tc), .b_tc(b_tc),
        .neg_tc(neg_tc), .y_mag(y_mag), .y_sign(y_sign)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s x=%b actual=%0d expected=%0d", req, x_sm, act, exp);
        end
    endtask

    function automatic int x_val(input logic [2:0] x);
        return x[2] ? -int'(x[1:0]) : int'(x[1:0]);
    endfunction

    task automatic apply(input logic [2:0] x);
        @(posedge clk);
        x_sm = x;
        @(negedge clk);
    endtask

    // Full reference check of one code
    task automatic check_code(input logic [2:0] x);
        int xv, y, ay;
        apply(x);
        xv = x_val(x);
        y  = 2 * xv - 1;
        ay = (y < 0) ? -y : y;
        chk("R4", int'(b_tc), y & 15);
        chk("R5", int'(neg_tc), (-y) & 15);
        chk("R6", int'(y_sign), (y < 0) ? 1 : 0);
        chk("R7", int'(y_mag), ay);
        chk("R8", (y_sign ? -int'(y_mag) : int'(y_mag)), y);
    endtask

    task automatic t_initial;
        @(negedge clk);
        chk("R1", int'(a_tc), 0);
        chk("R6", int'(y_sign), 1);
        chk("R7", int'(y_mag), 1);
    endtask

    task automatic t_positive;
        for (int m = 0; m < 4; m++) begin
            apply({1'b0, 2'(m)});
            chk("R1", int'(a_tc), m);
        end
    endtask

    task automatic t_negative;
        apply(3'b101); chk("R2", int'(a_tc), 3'b111);
        apply(3'b110); chk("R2", int'(a_tc), 3'b110);
        apply(3'b111); chk("R2", int'(a_tc), 3'b101);
        chk("R7", int'(y_mag), 7);
        chk("R5", int'(neg_tc), 4'b0111);
    endtask

    task automatic t_neg_zero;
        apply(3'b100);
        chk("R3", int'(a_tc), 0);
        chk("R3", int'(b_tc), 4'b1111);
        chk("R3", int'(y_sign), 1);
        chk("R3", int'(y_mag), 1);
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 8; c++)
            check_code(3'(c));
        // Reverse order as a second pattern
        for (int c = 7; c >= 0; c--)
            check_code(3'(c));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_initial;
        t_positive;
        t_negative;
        t_neg_zero;
        t_sweep;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule